// File: doc/BRIEF.md
# Round-Robin Context Switch Engine

The engine swaps the register state of one task for that of the next each time a watchdog interrupt strobe arrives. On a trigger it takes a copy of the interrupted task's snapshot. It writes that copy field by field into the task's record in an internal context RAM. It then steps a round-robin task pointer and reads the next task's record back onto the output snapshot bus. When that bus holds the complete new context, it raises a one-cycle completion strobe.

The design must recover on its own from corrupted state, so nothing it reads is trusted. The task pointer has exactly as many bits as the task count needs, so every value it can hold names a real task. On restore, the code-segment field is checked against a fixed per-task table and overwritten when it does not match. The instruction pointer is forced onto a 16-byte boundary. Whatever the RAM holds, the output is therefore always a context that can be resumed.

Top module: `csw_engine`

## Requirements
- R1: After reset the task pointer is 0, so the first switch saves into task 0's record and restores task 1's record.
- R2: Each switch advances the task pointer by exactly one, modulo NUM_TASKS (a power of two). After NUM_TASKS switches the engine restores the record it saved NUM_TASKS switches earlier.
- R3: A snapshot holds 13 fields of 16 bits, with field k on bits [16k+15:16k]: 0 flags, 1 code segment, 2 instruction pointer, 3 ax, 4 ds, 5 bx, 6 cx, 7 dx, 8 si, 9 di, 10 es, 11 fs, 12 gs. The input is sampled at the edge that accepts the trigger; later changes to it have no effect. Every field other than 1 and 2 is restored exactly as it was saved.
- R4: Field k of task t is stored at word address TBL_BASE + t*REC_WORDS + k. The RAM depth is derived so that no address exceeds it.
- R5: On restore, field 1 always equals the restored task's entry in the limit table. Entry t sits on bits [16t+15:16t]. A saved value that already matches is kept; any other value is replaced.
- R6: On restore, the low 4 bits of field 2 are cleared and its upper bits are kept.
- R7: A switch runs to completion without interruption, in the order save, advance, load, done. done_o is high in the cycle after the 29th rising edge, counting the edge that samples the trigger as the first.
- R8: Trigger pulses that arrive while a switch is in progress are ignored. They cause neither an extra switch nor an extra done_o.
- R9: done_o is high for exactly one cycle. snap_o holds the restored context unchanged until the next switch loads it.
- R10: During and after reset, done_o is low and snap_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Switch request strobe |
| snap_i | input | 13*DATA_W | Snapshot of the interrupted task |
| lim_tbl_i | input | NUM_TASKS*DATA_W | Fixed code-segment value for each task |
| snap_o | output | 13*DATA_W | Restored snapshot of the next task |
| done_o | output | 1 | One-cycle strobe: snap_o holds the new context |

## Verification
The main function is exercised with these snapshot patterns:
- A per-field ramp, which shows a misplaced field or a wrong record address as a value in the wrong slot.
- All ones, which makes both sanitizing rules change the value they act on.
- Alternating bit patterns.
- A snapshot whose code segment already matches the table, which confirms that a matching value passes through.

The switch sequence wraps the task pointer twice, so a wrong modulo order shows up as a restored record that belongs to the wrong task. Changing snap_i right after the trigger shows whether the input is sampled at the correct edge. A trigger pulsed in the middle of a switch shows whether the engine restarts or double-steps.

// File: rtl/csw_pkg.sv
package csw_pkg;
  localparam int NUM_FIELDS = 13;
  localparam int FLD_CS     = 1;
  localparam int FLD_IP     = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE,
    ST_ADV,
    ST_LOAD,
    ST_DONE
  } csw_state_e;
endpackage

// File: rtl/csw_addr_gen.sv
module csw_addr_gen #(
  parameter int IDX_W     = 2,
  parameter int FLD_W     = 4,
  parameter int AW        = 7,
  parameter int TBL_BASE  = 8,
  parameter int REC_WORDS = 16
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [FLD_W-1:0] fld_i,
  output logic [AW-1:0]    addr_o
);
  int unsigned sum;
  always_comb begin
    sum    = TBL_BASE + int'(idx_i) * REC_WORDS + int'(fld_i);
    addr_o = sum[AW-1:0];
  end
endmodule

// File: rtl/csw_ctx_ram.sv
module csw_ctx_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 72,
  parameter int AW    = 7
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/csw_sanitize.sv
module csw_sanitize #(
  parameter int NUM_TASKS  = 4,
  parameter int DW         = 16,
  parameter int IDX_W      = 2,
  parameter int FLD_W      = 4,
  parameter int ALIGN_BITS = 4
) (
  input  logic [FLD_W-1:0]        fld_i,
  input  logic [IDX_W-1:0]        task_i,
  input  logic [DW-1:0]           data_i,
  input  logic [NUM_TASKS*DW-1:0] lim_i,
  output logic [DW-1:0]           data_o
);
  logic [DW-1:0] lim_val;
  assign lim_val = lim_i[task_i*DW +: DW];

  always_comb begin
    data_o = data_i;
    if (int'(fld_i) == csw_pkg::FLD_CS && data_i != lim_val) data_o = lim_val;
    if (int'(fld_i) == csw_pkg::FLD_IP) data_o[ALIGN_BITS-1:0] = '0;
  end
endmodule

// File: rtl/csw_engine.sv
module csw_engine #(
  parameter int NUM_TASKS  = 4,
  parameter int DATA_W     = 16,
  parameter int REC_WORDS  = 16,
  parameter int TBL_BASE   = 8,
  parameter int ALIGN_BITS = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          trig_i,
  input  logic [13*DATA_W-1:0]          snap_i,
  input  logic [NUM_TASKS*DATA_W-1:0]   lim_tbl_i,
  output logic [13*DATA_W-1:0]          snap_o,
  output logic                          done_o
);
  import csw_pkg::*;

  localparam int NF     = NUM_FIELDS;
  localparam int IDX_W  = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1;
  localparam int CNT_W  = $clog2(NF + 1);
  localparam int DEPTH  = TBL_BASE + NUM_TASKS * REC_WORDS;
  localparam int AW     = $clog2(DEPTH);

  csw_state_e        st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] cap_q [NF];
  logic [13*DATA_W-1:0] out_q;
  logic              rd_vld_q;
  logic [CNT_W-1:0]  rd_fld_q;

  logic [CNT_W-1:0]  fld_sel;
  logic [AW-1:0]     ram_addr;
  logic [DATA_W-1:0] ram_rdata;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] san_data;
  logic              ram_we;
  logic              cnt_last;

  assign cnt_last  = (int'(cnt_q) == NF - 1);
  assign fld_sel   = (int'(cnt_q) < NF) ? cnt_q : '0;
  assign ram_we    = (st_q == ST_SAVE);
  assign ram_wdata = cap_q[fld_sel];

  csw_addr_gen #(
    .IDX_W(IDX_W), .FLD_W(CNT_W), .AW(AW),
    .TBL_BASE(TBL_BASE), .REC_WORDS(REC_WORDS)
  ) u_addr (
    .idx_i (idx_q),
    .fld_i (fld_sel),
    .addr_o(ram_addr)
  );

  csw_ctx_ram #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .addr_i (ram_addr),
    .wdata_i(ram_wdata),
    .rdata_o(ram_rdata)
  );

  csw_sanitize #(
    .NUM_TASKS(NUM_TASKS), .DW(DATA_W), .IDX_W(IDX_W),
    .FLD_W(CNT_W), .ALIGN_BITS(ALIGN_BITS)
  ) u_san (
    .fld_i (rd_fld_q),
    .task_i(idx_q),
    .data_i(ram_rdata),
    .lim_i (lim_tbl_i),
    .data_o(san_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      cnt_q    <= '0;
      rd_vld_q <= 1'b0;
      rd_fld_q <= '0;
      out_q    <= '0;
      for (int k = 0; k < NF; k++) cap_q[k] <= '0;
    end else begin
      rd_vld_q <= (st_q == ST_LOAD) && (int'(cnt_q) < NF);
      rd_fld_q <= cnt_q;
      if (rd_vld_q) out_q[rd_fld_q*DATA_W +: DATA_W] <= san_data;
      unique case (st_q)
        ST_IDLE: if (trig_i) begin
          for (int k = 0; k < NF; k++) cap_q[k] <= snap_i[k*DATA_W +: DATA_W];
          cnt_q <= '0;
          st_q  <= ST_SAVE;
        end
        ST_SAVE: begin
          if (cnt_last) st_q <= ST_ADV;
          else          cnt_q <= cnt_q + 1'b1;
        end
        ST_ADV: begin
          idx_q <= idx_q + 1'b1;  // wraps modulo NUM_TASKS by width
          cnt_q <= '0;
          st_q  <= ST_LOAD;
        end
        ST_LOAD: begin
          if (int'(cnt_q) == NF) st_q <= ST_DONE;
          else                   cnt_q <= cnt_q + 1'b1;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign snap_o = out_q;
  assign done_o = (st_q == ST_DONE);
endmodule

// File: rtl/csw_engine_chk.sv
module csw_engine_chk #(
  parameter int NUM_TASKS  = 4,
  parameter int DATA_W     = 16,
  parameter int IDX_W      = 2,
  parameter int ALIGN_BITS = 4,
  parameter int LAT        = 28
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        done_i,
  input logic                        busy_i,
  input logic [IDX_W-1:0]            idx_i,
  input logic [DATA_W-1:0]           cs_i,
  input logic [DATA_W-1:0]           ip_i,
  input logic [NUM_TASKS*DATA_W-1:0] lim_i
);
  localparam int LW = $clog2(LAT + 2);
  logic [LW-1:0]    lat_q;
  logic [IDX_W-1:0] start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q   <= '0;
      start_q <= '0;
    end else if (!busy_i) begin
      lat_q   <= '0;
      start_q <= idx_i;
    end else if (int'(lat_q) <= LAT) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
  assert_cs_forced_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> cs_i == lim_i[idx_i*DATA_W +: DATA_W]);
  assert_ip_aligned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> ip_i[ALIGN_BITS-1:0] == '0);
  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> int'(lat_q) == LAT);
  assert_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> idx_i == IDX_W'(start_q + 1'b1));
endmodule

bind csw_engine csw_engine_chk #(
  .NUM_TASKS (NUM_TASKS),
  .DATA_W    (DATA_W),
  .IDX_W     ((NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1),
  .ALIGN_BITS(ALIGN_BITS),
  .LAT       (2 * csw_pkg::NUM_FIELDS + 2)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .done_i(done_o),
  .busy_i(st_q != csw_pkg::ST_IDLE),
  .idx_i (idx_q),
  .cs_i  (snap_o[DATA_W +: DATA_W]),
  .ip_i  (snap_o[2*DATA_W +: DATA_W]),
  .lim_i (lim_tbl_i)
);

// File: tb/csw_engine_test.sv
module csw_engine_test;
  localparam int NT = 4;
  localparam int DW = 16;
  localparam int NF = 13;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              trig = 1'b0;
  logic [NF*DW-1:0]  snap_in = '0;
  logic [NT*DW-1:0]  lim;
  logic [NF*DW-1:0]  snap_out;
  logic              done;

  int errors = 0;
  int checks = 0;
  int cur_task = 0;
  logic [DW-1:0] model [NT][NF];
  bit            filled [NT];

  always #2 clk = ~clk;

  csw_engine #(.NUM_TASKS(NT), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .snap_i(snap_in),
    .lim_tbl_i(lim), .snap_o(snap_out), .done_o(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NF*DW-1:0] ramp(input logic [15:0] seed);
    logic [NF*DW-1:0] s;
    for (int k = 0; k < NF; k++) s[k*DW +: DW] = seed + 16'(k) * 16'h1111;
    return s;
  endfunction

  task automatic quiet_window(input int n);
    int extra = 0;
    logic [NF*DW-1:0] held = snap_out;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (done) extra++;
    end
    check("R8 no extra done", 32'(extra), 32'd0);
    check("R9 snap_o held", 32'(snap_out == held), 32'd1);
  endtask

  task automatic run_switch(input logic [NF*DW-1:0] s, input bit poke);
    int lat = 0;
    int nxt;
    logic [NF*DW-1:0] held;
    @(negedge clk);
    snap_in = s; trig = 1'b1;
    @(posedge clk); lat = 1;
    @(negedge clk);
    trig = 1'b0;
    snap_in = ~s;  // R3: must not reach the saved record
    for (int k = 0; k < NF; k++) model[cur_task][k] = s[k*DW +: DW];
    filled[cur_task] = 1'b1;
    nxt = (cur_task + 1) % NT;
    while (!done && lat < 100) begin
      if (poke && (lat == 5 || lat == 20)) trig = 1'b1;
      @(posedge clk); lat++;
      @(negedge clk); trig = 1'b0;
    end
    check("R7 latency", 32'(lat), 32'd29);
    check("R5 cs", 32'(snap_out[DW +: DW]), 32'(lim[nxt*DW +: DW]));
    check("R6 ip low", 32'(snap_out[2*DW +: 4]), 32'd0);
    if (filled[nxt]) begin
      check("R6 ip high", 32'(snap_out[2*DW +: DW]), 32'(model[nxt][2] & 16'hFFF0));
      for (int k = 0; k < NF; k++)
        if (k != 1 && k != 2)
          check($sformatf("R2 R3 R4 task%0d field%0d", nxt, k),
                32'(snap_out[k*DW +: DW]), 32'(model[nxt][k]));
    end
    held = snap_out;
    @(posedge clk); @(negedge clk);
    check("R9 done one cycle", 32'(done), 32'd0);
    check("R9 snap_o stable", 32'(snap_out == held), 32'd1);
    cur_task = nxt;
  endtask

  initial begin
    logic [NF*DW-1:0] s;
    for (int t = 0; t < NT; t++) begin
      lim[t*DW +: DW] = 16'hC000 | 16'(t * 16'h0101);
      filled[t] = 1'b0;
    end
    #1;
    check("R10 reset done", 32'(done), 32'd0);
    check("R10 reset snap", 32'(snap_out == '0), 32'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R10 post reset done", 32'(done), 32'd0);
    // R1: first switch saves task 0, restores task 1
    run_switch(ramp(16'h0000), 1'b0);
    run_switch({NF*DW{1'b1}}, 1'b0);
    s = '0;
    for (int k = 0; k < NF; k++) s[k*DW +: DW] = (k % 2 == 0) ? 16'hA5A5 : 16'h5A5A;
    run_switch(s, 1'b0);
    run_switch(ramp(16'h1234), 1'b0);  // wrap: restores task 0
    s = ramp(16'h0F0F);
    s[DW +: DW] = lim[0 +: DW];  // matching cs kept (R5)
    s[2*DW +: DW] = 16'h7FFF;
    run_switch(s, 1'b0);
    run_switch(ramp(16'h2468), 1'b1);  // R8 mid-switch pulses
    quiet_window(35);
    for (int i = 0; i < 4; i++) run_switch(ramp(16'(16'h3000 + i * 16'h0123)), 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule